// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside one processor and backs load-linked / store-conditional sequences. An exclusive load arms a single reservation: a granule tag plus a valid flag. A later exclusive store writes memory only if that reservation is still intact and covers the store address. The monitor answers each exclusive store in the same cycle. It drives the memory write-enable and returns a status word: zero on success, one on failure. Software that sees a failure loops back and retries the whole read-modify-write.

The reservation is tracked per granule of 2^GRAN_LOG2 bytes, and the address bits below that size play no part in any compare. The reservation is dropped in any of these cases:
- a committed write from another bus master lands in the reserved granule;
- the processor takes an exception or issues a clear request;
- any exclusive store is made.

A mode pin widens the granule to the whole address space. In that mode every foreign commit cancels the reservation and every exclusive store address is covered. Each processor owns its own monitor, so monitors that hold different granules never disturb one another.

Top module: `excl_monitor`

## Requirements
- R1: A request with `req_op`=0 (exclusive load) and no exception in the same cycle records the granule tag of `req_addr`, and `resv_held` reads 1 from the next cycle.
- R2: A request with `req_op`=1 (exclusive store) passes only if all of these hold in that cycle: a reservation is held, its tag equals the granule of `req_addr` (or global mode is on), no foreign commit hits it, and `exc_entry` is low. A pass gives `mem_we`=1 and `xst_status`=0 in the same cycle.
- R3: A failing exclusive store gives `xst_status`=1 and `mem_we`=0 in the same cycle.
- R4: A foreign commit (`snoop_valid`) to the reserved granule clears the reservation. An exclusive store in the same cycle as that commit fails.
- R5: Either a clear request (`req_op`=3) or `exc_entry` clears the reservation. `exc_entry` also fails a same-cycle exclusive store and suppresses a same-cycle exclusive load.
- R6: With `cfg_global`=1, every foreign commit hits the reservation and every exclusive store address is covered.
- R7: Every exclusive store clears the reservation, whether it passes or fails. A second exclusive store with no exclusive load in between fails.
- R8: A new exclusive load replaces the stored tag. An exclusive load takes effect even when a foreign commit to the old granule arrives in the same cycle.
- R9: The address bits below GRAN_LOG2 are ignored in every tag compare.
- R10: A plain store (`req_op`=2) gives `mem_we`=1 and `xst_status`=0, and leaves the reservation unchanged.
- R11: Reset clears the reservation.
- R12: Two monitors holding different granules, each snooping the other's commits, both pass exclusive stores issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_global | input | 1 | Treat the whole address space as one granule |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 exclusive load, 1 exclusive store, 2 plain store, 3 clear |
| req_addr | input | ADDR_W | Request byte address |
| snoop_valid | input | 1 | Committed write from another master |
| snoop_addr | input | ADDR_W | Address of that committed write |
| exc_entry | input | 1 | Exception-entry pulse |
| mem_we | output | 1 | Memory write-enable for this request |
| xst_status | output | STAT_W | Exclusive store status, 0 pass, 1 fail |
| resv_held | output | 1 | Reservation valid flag |

## Verification
The bench builds two monitors with a 16-bit address and a 16-byte granule (GRAN_LOG2=4). Each monitor's write-enable is fed, one cycle later, into the other monitor's snoop port. The random phase spreads addresses over only eight granules, so same-granule collisions between the two processors are frequent. It also switches `cfg_global` during the run, so both the tag-compare path and the global path meet foreign commits, exceptions and back-to-back exclusive pairs.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 6,
  parameter int STAT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_global,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              exc_entry,
  output logic              mem_we,
  output logic [STAT_W-1:0] xst_status,
  output logic              resv_held
);
  localparam int TAG_W = ADDR_W - GRAN_LOG2;
  localparam logic [1:0] OP_XLD = 2'd0, OP_XST = 2'd1, OP_ST = 2'd2, OP_CLR = 2'd3;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  wire [TAG_W-1:0] req_tag   = req_addr[ADDR_W-1:GRAN_LOG2];
  wire [TAG_W-1:0] snoop_tag = snoop_addr[ADDR_W-1:GRAN_LOG2];

  wire is_xld = req_valid && req_op == OP_XLD;
  wire is_xst = req_valid && req_op == OP_XST;
  wire is_st  = req_valid && req_op == OP_ST;
  wire is_clr = req_valid && req_op == OP_CLR;

  wire snoop_kill = valid_q && snoop_valid && (cfg_global || snoop_tag == tag_q);
  wire covered    = valid_q && (cfg_global || req_tag == tag_q);
  wire xst_pass   = is_xst && covered && !snoop_kill && !exc_entry;

  assign mem_we     = is_st || xst_pass;
  assign xst_status = STAT_W'(is_xst && !xst_pass);
  assign resv_held  = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (is_xld && !exc_entry) begin
      valid_q <= 1'b1;
      tag_q   <= req_tag;
    end else if (exc_entry || is_clr || is_xst || snoop_kill) begin
      valid_q <= 1'b0;
    end
  end

  // R1
  xld_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xld && !exc_entry) |=> resv_held);
  // R7
  xst_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_xst |=> !resv_held);
  // R6
  global_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && cfg_global && !is_xld) |=> !resv_held);
  // R5
  exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !resv_held);
  // R3
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xst && xst_status != '0) |-> !mem_we);
  // R2
  pass_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xst && mem_we) |-> resv_held);
  // R10
  plain_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_st && !exc_entry && !snoop_valid) |=> resv_held == $past(resv_held));
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int GL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob = 1'b0;
  logic          rv   [2];
  logic [1:0]    rop  [2];
  logic [AW-1:0] ra   [2];
  logic          exc  [2];
  logic          sv   [2];
  logic [AW-1:0] sa   [2];
  logic          we   [2];
  logic [31:0]   st   [2];
  logic          held [2];

  int checks = 0, errors = 0;
  bit done = 0;
  bit mv [2];
  int mt [2];
  bit msv [2];
  int msa [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRAN_LOG2(GL), .STAT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_global(glob),
    .req_valid(rv[0]), .req_op(rop[0]), .req_addr(ra[0]),
    .snoop_valid(sv[0]), .snoop_addr(sa[0]), .exc_entry(exc[0]),
    .mem_we(we[0]), .xst_status(st[0]), .resv_held(held[0]));

  excl_monitor #(.ADDR_W(AW), .GRAN_LOG2(GL), .STAT_W(32)) u_peer (
    .clk(clk), .rst_n(rst_n), .cfg_global(glob),
    .req_valid(rv[1]), .req_op(rop[1]), .req_addr(ra[1]),
    .snoop_valid(sv[1]), .snoop_addr(sa[1]), .exc_entry(exc[1]),
    .mem_we(we[1]), .xst_status(st[1]), .resv_held(held[1]));

  always @(posedge clk) begin
    if (!rst_n) begin
      sv[0] <= 1'b0; sv[1] <= 1'b0; sa[0] <= '0; sa[1] <= '0;
    end else begin
      sv[0] <= we[1]; sa[0] <= ra[1];
      sv[1] <= we[0]; sa[1] <= ra[0];
    end
  end

  function automatic int tagof(input int a);
    return a >> GL;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit nv [2];
    int nt [2];
    bit nsv [2];
    int nsa [2];
    #1;
    for (int i = 0; i < 2; i++) begin
      bit hit, isx, pass, ewe, est;
      hit  = msv[i] && (glob || tagof(msa[i]) == mt[i]);
      isx  = rv[i] && rop[i] == 2'd1;
      pass = isx && mv[i] && (glob || tagof(int'(ra[i])) == mt[i]) && !hit && !exc[i];
      ewe  = rv[i] && (rop[i] == 2'd2 || pass);
      est  = isx && !pass;
      check(we[i] == ewe, tag, $sformatf("mem_we[%0d]", i), int'(we[i]), int'(ewe));
      check(st[i] == 32'(est), tag, $sformatf("status[%0d]", i), int'(st[i]), int'(est));
      check(held[i] == mv[i], tag, $sformatf("held[%0d]", i), int'(held[i]), int'(mv[i]));
      nv[i] = mv[i]; nt[i] = mt[i];
      if (rv[i] && rop[i] == 2'd0 && !exc[i]) begin
        nv[i] = 1; nt[i] = tagof(int'(ra[i]));
      end else if (exc[i] || (rv[i] && (rop[i] == 2'd3 || rop[i] == 2'd1)) || (mv[i] && hit)) begin
        nv[i] = 0;
      end
      nsv[1-i] = ewe; nsa[1-i] = int'(ra[i]);
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      mv[i] = nv[i]; mt[i] = nt[i]; msv[i] = nsv[i]; msa[i] = nsa[i];
    end
    @(negedge clk);
  endtask

  task automatic go(input logic v0, input logic [1:0] o0, input logic [AW-1:0] a0,
                    input logic v1, input logic [1:0] o1, input logic [AW-1:0] a1,
                    input logic e0, input string tag);
    rv[0] = v0; rop[0] = o0; ra[0] = a0; exc[0] = e0;
    rv[1] = v1; rop[1] = o1; ra[1] = a1; exc[1] = 1'b0;
    step(tag);
  endtask

  task automatic idle(input string tag);
    go(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      rv[i] = 0; rop[i] = 0; ra[i] = 0; exc[i] = 0;
      mv[i] = 0; mt[i] = 0; msv[i] = 0; msa[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R11");
    // R1
    go(1, 0, 16'h0120, 0, 0, 0, 0, "R1");
    idle("R1");
    // R9: same granule, different low bits
    go(1, 1, 16'h012C, 0, 0, 0, 0, "R9");
    // R7: second exclusive store fails
    go(1, 1, 16'h0120, 0, 0, 0, 0, "R7");
    go(1, 0, 16'h0130, 0, 0, 0, 0, "R7");
    go(1, 1, 16'h0134, 0, 0, 0, 0, "R7");
    go(1, 1, 16'h0134, 0, 0, 0, 0, "R7");
    // R2: other granule fails
    go(1, 0, 16'h0200, 0, 0, 0, 0, "R2");
    go(1, 1, 16'h0210, 0, 0, 0, 0, "R2");
    // R3: store without reservation
    go(1, 1, 16'h0220, 0, 0, 0, 0, "R3");
    // R10: plain store keeps reservation
    go(1, 0, 16'h0300, 0, 0, 0, 0, "R10");
    go(1, 2, 16'h0300, 0, 0, 0, 0, "R10");
    go(1, 1, 16'h0300, 0, 0, 0, 0, "R10");
    // R4: foreign commit same granule, then store
    go(1, 0, 16'h0400, 0, 0, 0, 0, "R4");
    go(0, 0, 0, 1, 2, 16'h0408, 0, "R4");
    idle("R4");
    go(1, 1, 16'h0400, 0, 0, 0, 0, "R4");
    // R4: foreign commit arriving in the same cycle as the store
    go(1, 0, 16'h0400, 0, 0, 0, 0, "R4");
    go(0, 0, 0, 1, 2, 16'h0404, 0, "R4");
    go(1, 1, 16'h0400, 0, 0, 0, 0, "R4");
    // R4: foreign commit elsewhere leaves it
    go(1, 0, 16'h0400, 0, 0, 0, 0, "R4");
    go(0, 0, 0, 1, 2, 16'h0500, 0, "R4");
    idle("R4");
    go(1, 1, 16'h0400, 0, 0, 0, 0, "R4");
    // R5: clear request, exception, exception with load, exception with store
    go(1, 0, 16'h0600, 0, 0, 0, 0, "R5");
    go(1, 3, 16'h0000, 0, 0, 0, 0, "R5");
    go(1, 1, 16'h0600, 0, 0, 0, 0, "R5");
    go(1, 0, 16'h0600, 0, 0, 0, 0, "R5");
    go(0, 0, 0, 0, 0, 0, 1, "R5");
    go(1, 1, 16'h0600, 0, 0, 0, 0, "R5");
    go(1, 0, 16'h0600, 0, 0, 0, 1, "R5");
    idle("R5");
    go(1, 0, 16'h0600, 0, 0, 0, 0, "R5");
    go(1, 1, 16'h0600, 0, 0, 0, 1, "R5");
    // R8: reload replaces tag
    go(1, 0, 16'h0600, 0, 0, 0, 0, "R8");
    go(1, 0, 16'h0700, 0, 0, 0, 0, "R8");
    go(1, 1, 16'h0600, 0, 0, 0, 0, "R8");
    go(1, 0, 16'h0600, 0, 0, 0, 0, "R8");
    go(1, 0, 16'h0700, 0, 0, 0, 0, "R8");
    go(1, 1, 16'h0700, 0, 0, 0, 0, "R8");
    // R8: load wins over same-cycle foreign commit
    go(1, 0, 16'h0800, 0, 0, 0, 0, "R8");
    go(0, 0, 0, 1, 2, 16'h0800, 0, "R8");
    go(1, 0, 16'h0800, 0, 0, 0, 0, "R8");
    go(1, 1, 16'h0800, 0, 0, 0, 0, "R8");
    // R6: global granule
    glob = 1'b1;
    go(1, 0, 16'h0100, 0, 0, 0, 0, "R6");
    go(1, 1, 16'h0F00, 0, 0, 0, 0, "R6");
    go(1, 0, 16'h0100, 0, 0, 0, 0, "R6");
    go(0, 0, 0, 1, 2, 16'h0F00, 0, "R6");
    idle("R6");
    go(1, 1, 16'h0100, 0, 0, 0, 0, "R6");
    glob = 1'b0;
    // R12: independent progress
    go(1, 0, 16'h1000, 1, 0, 16'h2000, 0, "R12");
    go(1, 1, 16'h1000, 1, 1, 16'h2000, 0, "R12");
    idle("R12");
    // random mix on a small window
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) glob = ~glob;
      for (int i = 0; i < 2; i++) begin
        rv[i]  = ($urandom % 4) != 0;
        rop[i] = 2'($urandom % 4);
        ra[i]  = AW'($urandom % 128);
        exc[i] = ($urandom % 16) == 0;
      end
      step("R2");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule